// File: doc/BRIEF.md
# Thread Block Warp Dispatcher

This block sits in front of a multiprocessor's four warp pools and decides when a thread-block launch may enter. Each launch request names a thread count. The dispatcher turns that count into a number of 32-lane warps. It holds the request until the multiprocessor has enough free warp slots for the whole block. It then reserves those slots and hands the warps out to the subpartitions, one warp per clock. Each warp carries a block tag, its index inside the block, the slot it occupies and an active-lane mask.

Warps finish independently. A completion input for each subpartition names the slot that has retired, and that slot becomes free at once. A per-block counter follows how many of a block's warps are still alive. When the last one reports, the block's bit pulses on a done vector. Requests are served strictly in arrival order through a single valid/ready channel. A request whose thread count is zero or above the block limit is consumed and flagged as rejected.

Top module: `warp_dispatch_top`

## Requirements
- R1: After reset no warp allocate, block-done or reject pulse is driven, all 64 warp slots are free, and `req_ready` is low whenever `req_valid` is low.
- R2: A request with a thread count of 0 or above 1024 is consumed in the cycle it is offered (ready high). `req_reject` pulses in the cycle after that accepting edge, and no warp is allocated for it.
- R3: An accepted block of T threads produces exactly ceil(T/32) warp allocations, on consecutive cycles, with warp indices 0, 1, 2 and so on. The first allocation is visible one clock edge after the first edge following acceptance.
- R4: `alloc_mask` is all 32 lanes set for every warp except the last one. When T mod 32 is nonzero, the last warp has only its low (T mod 32) bits set.
- R5: A legal request is accepted only when the count of unreserved warp slots is at least its warp count. While this is not true, `req_ready` stays low.
- R6: Warp k of the dispatch stream goes to the first subpartition, in the order p, p+1, … modulo 4, that has a free slot. Here p is one past the subpartition used by the previous warp, and the search starts at subpartition 0 after reset. `alloc_valid` is one-hot, with bit i meaning subpartition i.
- R7: Each subpartition holds 16 slots. A warp takes the lowest-numbered free slot of its subpartition, shown on `alloc_slot`. A `done_valid[i]` pulse with slot number s in `done_slot[4i+3:4i]` frees that slot.
- R8: `blk_done[t]` pulses for one cycle, in the cycle after the edge at which the last outstanding warp of the block with tag t is reported complete.
- R9: At acceptance `req_tag` shows the lowest tag with no live warps. Every warp of that block carries the same tag on `alloc_tag`.
- R10: Completions on several subpartitions in one cycle, including several warps of one block, are all counted. A completion sampled at the same edge as an acceptance is counted as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Launch request offered |
| req_ready | output | 1 | Request consumed at this edge |
| req_threads | input | 12 | Thread count of the block |
| req_tag | output | 6 | Tag given to the block being accepted |
| req_reject | output | 1 | Pulse: previous accepted request was illegal |
| alloc_valid | output | 4 | One-hot warp allocate, one bit per subpartition |
| alloc_tag | output | 6 | Block tag of the allocated warp |
| alloc_warp | output | 5 | Warp index inside its block |
| alloc_slot | output | 4 | Slot taken in the target subpartition |
| alloc_mask | output | 32 | Active-lane mask of the warp |
| done_valid | input | 4 | Warp-complete pulse per subpartition |
| done_slot | input | 16 | Completed slot number, 4 bits per subpartition |
| blk_done | output | 64 | One-cycle pulse per block tag on block completion |

## Verification
Two functions can fall in the same cycle. One is the admission of a block, which reserves warp slots. The other is the retirement of warps from older blocks, which returns slots; both change the single free-slot count at one edge. The bench provokes this by freeing exactly one slot and then offering a one-warp block while another warp completes at the accepting edge. A second one-warp block must then be taken at once and a third refused, which is correct only if the free count came out at one after the first admission. The bench also retires four warps of one block in a single cycle, and the block-done pulse must arrive exactly when the last batch lands.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_ISSUE = 1'b1
    } phase_e;

endpackage

// File: rtl/wd_slot_pool.sv
module wd_slot_pool #(
    parameter int SUBS  = 4,
    parameter int SLOTS = 16,
    parameter int TAGW  = 6,
    parameter int SUBW  = 2,
    parameter int SLOTW = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_valid,
    input  logic [SUBW-1:0]         set_sub,
    input  logic [TAGW-1:0]         set_tag,
    input  logic [SUBS-1:0]         done_valid,
    input  logic [SUBS*SLOTW-1:0]   done_slot,
    output logic [SUBS-1:0]         has_free,
    output logic [SUBS*SLOTW-1:0]   first_free,
    output logic [SUBS*TAGW-1:0]    done_tag
);

    for (genvar s = 0; s < SUBS; s++) begin : g_sub
        typedef struct packed {
            logic [SLOTS-1:0]           busy;
            logic [SLOTS-1:0][TAGW-1:0] tag;
        } pool_t;

        pool_t             st_q, st_d;
        logic [SLOTW-1:0]  dslot;
        logic [SLOTW-1:0]  free_idx;

        assign dslot = done_slot[s*SLOTW +: SLOTW];

        // lowest free slot of this subpartition
        always_comb begin
            free_idx = '0;
            for (int i = SLOTS - 1; i >= 0; i--) begin
                if (!st_q.busy[i]) free_idx = SLOTW'(i);
            end
        end

        always_comb begin
            st_d = st_q;
            if (done_valid[s]) st_d.busy[dslot] = 1'b0;
            if (set_valid && (set_sub == SUBW'(s))) begin
                st_d.busy[free_idx] = 1'b1;
                st_d.tag[free_idx]  = set_tag;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign has_free[s]                     = ~&st_q.busy;
        assign first_free[s*SLOTW +: SLOTW]    = free_idx;
        assign done_tag[s*TAGW +: TAGW]        = st_q.tag[dslot];

        // R7: a completion must name an occupied slot
        a_r7_done_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
            done_valid[s] |-> st_q.busy[dslot])
            else $error("completion on idle slot");
    end

endmodule

// File: rtl/wd_block_track.sv
module wd_block_track #(
    parameter int SUBS = 4,
    parameter int TAGS = 64,
    parameter int TAGW = 6,
    parameter int CNTW = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_valid,
    input  logic [TAGW-1:0]       load_tag,
    input  logic [CNTW-1:0]       load_cnt,
    input  logic [SUBS-1:0]       done_valid,
    input  logic [SUBS*TAGW-1:0]  done_tag,
    output logic [TAGS-1:0]       tag_free,
    output logic [TAGS-1:0]       blk_done
);

    typedef struct packed {
        logic [TAGS-1:0][CNTW-1:0] cnt;
        logic [TAGS-1:0]           fin;
    } trk_t;

    trk_t                      q, d;
    logic [TAGS-1:0][CNTW-1:0] dec;

    always_comb begin
        for (int t = 0; t < TAGS; t++) begin
            dec[t] = '0;
            for (int s = 0; s < SUBS; s++) begin
                if (done_valid[s] && (done_tag[s*TAGW +: TAGW] == TAGW'(t)))
                    dec[t] = dec[t] + CNTW'(1);
            end
        end
    end

    always_comb begin
        d = q;
        for (int t = 0; t < TAGS; t++) begin
            d.fin[t] = (dec[t] != '0) && (dec[t] == q.cnt[t]);
            d.cnt[t] = q.cnt[t] - dec[t];
            if (load_valid && (load_tag == TAGW'(t))) d.cnt[t] = load_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar t = 0; t < TAGS; t++) begin : g_tag
        assign tag_free[t] = (q.cnt[t] == '0);

        // R8: completions never exceed the live warps of a block
        a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            dec[t] <= q.cnt[t])
            else $error("block counter underflow");
    end

    assign blk_done = q.fin;

    // R9: a new block only takes a tag with no live warps
    a_r9_load_free_tag: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> tag_free[load_tag])
        else $error("tag reused while live");

endmodule

// File: rtl/wd_admit.sv
module wd_admit
    import wd_pkg::*;
#(
    parameter int LANES       = 32,
    parameter int MAX_THREADS = 1024,
    parameter int SUBS        = 4,
    parameter int TOTAL       = 64,
    parameter int TAGS        = 64,
    parameter int TW          = 12,
    parameter int TAGW        = 6,
    parameter int SUBW        = 2,
    parameter int SLOTW       = 4,
    parameter int WIDW        = 5,
    parameter int CNTW        = 6,
    parameter int FREEW       = 7,
    parameter int LSH         = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [TW-1:0]         req_threads,
    output logic                  req_ready,
    output logic [TAGW-1:0]       req_tag,
    output logic                  req_reject,
    input  logic [SUBS-1:0]       has_free,
    input  logic [SUBS*SLOTW-1:0] first_free,
    input  logic [TAGS-1:0]       tag_free,
    input  logic [SUBS-1:0]       done_valid,
    output logic                  set_valid,
    output logic [SUBW-1:0]       set_sub,
    output logic [TAGW-1:0]       set_tag,
    output logic                  load_valid,
    output logic [TAGW-1:0]       load_tag,
    output logic [CNTW-1:0]       load_cnt,
    output logic [SUBS-1:0]       alloc_valid,
    output logic [TAGW-1:0]       alloc_tag,
    output logic [WIDW-1:0]       alloc_warp,
    output logic [SLOTW-1:0]      alloc_slot,
    output logic [LANES-1:0]      alloc_mask
);

    typedef struct packed {
        phase_e           phase;
        logic [FREEW-1:0] free;
        logic [SUBW-1:0]  rr;
        logic [CNTW-1:0]  left;
        logic [WIDW-1:0]  widx;
        logic [TAGW-1:0]  tag;
        logic [LSH-1:0]   tail;
        logic [SUBS-1:0]  av;
        logic [TAGW-1:0]  atag;
        logic [WIDW-1:0]  awarp;
        logic [SLOTW-1:0] aslot;
        logic [LANES-1:0] amask;
        logic             rej;
    } adm_t;

    adm_t             q, d;
    logic [TW-1:0]    nw;
    logic             bad;
    logic             fits;
    logic             accept;
    logic             found;
    logic [SUBW-1:0]  pick;
    logic [SUBW-1:0]  cand;
    logic [TAGW-1:0]  low_tag;

    // request decode
    always_comb begin
        nw   = TW'((32'(req_threads) + 32'(LANES - 1)) >> LSH);
        bad  = (req_threads == '0) || (32'(req_threads) > 32'(MAX_THREADS));
        fits = 32'(q.free) >= 32'(nw);
        low_tag = '0;
        for (int t = TAGS - 1; t >= 0; t--) begin
            if (tag_free[t]) low_tag = TAGW'(t);
        end
    end

    // round-robin subpartition search from the pointer
    always_comb begin
        found = 1'b0;
        pick  = '0;
        cand  = '0;
        for (int k = 0; k < SUBS; k++) begin
            cand = SUBW'(32'(q.rr) + k);
            if (!found && has_free[cand]) begin
                found = 1'b1;
                pick  = cand;
            end
        end
    end

    always_comb begin
        d          = q;
        d.av       = '0;
        d.rej      = 1'b0;
        set_valid  = 1'b0;
        set_sub    = pick;
        load_valid = 1'b0;
        accept     = (q.phase == PH_IDLE) && req_valid && (bad || fits);
        d.free     = q.free + FREEW'($countones(done_valid));

        if (accept) begin
            if (bad) begin
                d.rej = 1'b1;
            end else begin
                d.phase    = PH_ISSUE;
                d.left     = CNTW'(nw);
                d.widx     = '0;
                d.tag      = low_tag;
                d.tail     = req_threads[LSH-1:0];
                d.free     = d.free - FREEW'(nw);
                load_valid = 1'b1;
            end
        end

        if (q.phase == PH_ISSUE) begin
            if (found) begin
                set_valid  = 1'b1;
                d.av[pick] = 1'b1;
            end
            d.atag  = q.tag;
            d.awarp = q.widx;
            d.aslot = first_free[pick*SLOTW +: SLOTW];
            if ((q.left == CNTW'(1)) && (q.tail != '0))
                d.amask = (LANES'(1) << q.tail) - LANES'(1);
            else
                d.amask = '1;
            d.left = q.left - CNTW'(1);
            d.widx = q.widx + WIDW'(1);
            d.rr   = pick + SUBW'(1);
            if (q.left == CNTW'(1)) d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.free <= FREEW'(TOTAL);
        end else begin
            q <= d;
        end
    end

    assign req_ready   = accept;
    assign req_tag     = low_tag;
    assign req_reject  = q.rej;
    assign set_tag     = q.tag;
    assign load_tag    = low_tag;
    assign load_cnt    = CNTW'(nw);
    assign alloc_valid = q.av;
    assign alloc_tag   = q.atag;
    assign alloc_warp  = q.awarp;
    assign alloc_slot  = q.aslot;
    assign alloc_mask  = q.amask;

    // R5: reserved capacity guarantees a physical slot for every pending warp
    a_r5_room_for_warp: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_ISSUE) |-> (|has_free))
        else $error("no free slot while issuing");

    // R5: unreserved count never exceeds the pool size
    a_r5_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(q.free) <= 32'(TOTAL))
        else $error("free count overflow");

    // R6: at most one subpartition receives a warp per cycle
    a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_valid))
        else $error("allocate not one-hot");

    // R2: a rejected request produces no allocation in the following cycle
    a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |=> (alloc_valid == '0))
        else $error("allocation after reject");

endmodule

// File: rtl/warp_dispatch_top.sv
module warp_dispatch_top #(
    parameter int LANES       = 32,
    parameter int MAX_THREADS = 1024,
    parameter int SUBS        = 4,
    parameter int SLOTS       = 16,
    localparam int TOTAL      = SUBS * SLOTS,
    localparam int TAGS       = TOTAL,
    localparam int WPB        = MAX_THREADS / LANES,
    localparam int TW         = $clog2(MAX_THREADS) + 2,
    localparam int TAGW       = $clog2(TAGS),
    localparam int SUBW       = $clog2(SUBS),
    localparam int SLOTW      = $clog2(SLOTS),
    localparam int WIDW       = $clog2(WPB),
    localparam int CNTW       = $clog2(WPB + 1),
    localparam int FREEW      = $clog2(TOTAL + 1),
    localparam int LSH        = $clog2(LANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [TW-1:0]         req_threads,
    output logic [TAGW-1:0]       req_tag,
    output logic                  req_reject,
    output logic [SUBS-1:0]       alloc_valid,
    output logic [TAGW-1:0]       alloc_tag,
    output logic [WIDW-1:0]       alloc_warp,
    output logic [SLOTW-1:0]      alloc_slot,
    output logic [LANES-1:0]      alloc_mask,
    input  logic [SUBS-1:0]       done_valid,
    input  logic [SUBS*SLOTW-1:0] done_slot,
    output logic [TAGS-1:0]       blk_done
);

    logic                  set_valid;
    logic [SUBW-1:0]       set_sub;
    logic [TAGW-1:0]       set_tag;
    logic                  load_valid;
    logic [TAGW-1:0]       load_tag;
    logic [CNTW-1:0]       load_cnt;
    logic [SUBS-1:0]       has_free;
    logic [SUBS*SLOTW-1:0] first_free;
    logic [SUBS*TAGW-1:0]  done_tag;
    logic [TAGS-1:0]       tag_free;

    wd_admit #(
        .LANES(LANES), .MAX_THREADS(MAX_THREADS), .SUBS(SUBS), .TOTAL(TOTAL),
        .TAGS(TAGS), .TW(TW), .TAGW(TAGW), .SUBW(SUBW), .SLOTW(SLOTW),
        .WIDW(WIDW), .CNTW(CNTW), .FREEW(FREEW), .LSH(LSH)
    ) u_admit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_threads(req_threads),
        .req_ready(req_ready), .req_tag(req_tag), .req_reject(req_reject),
        .has_free(has_free), .first_free(first_free), .tag_free(tag_free),
        .done_valid(done_valid),
        .set_valid(set_valid), .set_sub(set_sub), .set_tag(set_tag),
        .load_valid(load_valid), .load_tag(load_tag), .load_cnt(load_cnt),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_warp(alloc_warp),
        .alloc_slot(alloc_slot), .alloc_mask(alloc_mask)
    );

    wd_slot_pool #(
        .SUBS(SUBS), .SLOTS(SLOTS), .TAGW(TAGW), .SUBW(SUBW), .SLOTW(SLOTW)
    ) u_pool (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_sub(set_sub), .set_tag(set_tag),
        .done_valid(done_valid), .done_slot(done_slot),
        .has_free(has_free), .first_free(first_free), .done_tag(done_tag)
    );

    wd_block_track #(
        .SUBS(SUBS), .TAGS(TAGS), .TAGW(TAGW), .CNTW(CNTW)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .load_valid(load_valid), .load_tag(load_tag), .load_cnt(load_cnt),
        .done_valid(done_valid), .done_tag(done_tag),
        .tag_free(tag_free), .blk_done(blk_done)
    );

endmodule

// File: tb/test_warp_dispatch_top.sv
module test_warp_dispatch_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_threads = '0;
    logic [5:0]  req_tag;
    logic        req_reject;
    logic [3:0]  alloc_valid;
    logic [5:0]  alloc_tag;
    logic [4:0]  alloc_warp;
    logic [3:0]  alloc_slot;
    logic [31:0] alloc_mask;
    logic [3:0]  done_valid = '0;
    logic [15:0] done_slot = '0;
    logic [63:0] blk_done;

    warp_dispatch_top i_warp_dispatch_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_threads(req_threads),
        .req_tag(req_tag), .req_reject(req_reject),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_warp(alloc_warp),
        .alloc_slot(alloc_slot), .alloc_mask(alloc_mask),
        .done_valid(done_valid), .done_slot(done_slot), .blk_done(blk_done)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model of the pools, derived from the requirements
    bit mbusy[4][16];
    int mtag[4][16];
    int mcnt[64];
    int mfree = 64;
    int mrr = 0;

    task automatic chk(input bit ok, input string rq, input string nm,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, nm, act, exp);
        end
    endtask

    function automatic int low_tag();
        for (int t = 0; t < 64; t++) if (mcnt[t] == 0) return t;
        return 0;
    endfunction

    task automatic retire_model(input int s, input int sl, inout logic [63:0] m);
        int t;
        t = mtag[s][sl];
        mbusy[s][sl] = 0;
        mcnt[t]--;
        mfree++;
        if (mcnt[t] == 0) m[t] = 1'b1;
    endtask

    // offer one request; acc=1 when it was consumed
    task automatic send_req(input int T, input int cs, input int cslot, output bit acc);
        bit bad;
        int nw;
        bit exp_rdy;
        int et;
        logic [63:0] expd;
        bad = (T == 0) || (T > 1024);
        nw = (T + 31) / 32;
        exp_rdy = bad || (mfree >= nw);
        et = low_tag();
        expd = '0;
        acc = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_threads = 12'(T);
        if (cs >= 0) begin
            done_valid[cs] = 1'b1;
            done_slot[cs*4 +: 4] = 4'(cslot);
        end
        #1;
        chk(req_ready == exp_rdy, "R5", "ready", 64'(req_ready), 64'(exp_rdy));
        if (!req_ready) begin
            req_valid = 1'b0;
            done_valid = '0;
            return;
        end
        acc = 1;
        if (!bad) chk(req_tag == 6'(et), "R9", "req_tag", 64'(req_tag), 64'(et));
        if (cs >= 0) retire_model(cs, cslot, expd);
        @(negedge clk);
        req_valid = 1'b0;
        done_valid = '0;
        chk(req_reject == bad, "R2", "reject", 64'(req_reject), 64'(bad));
        chk(blk_done == expd, "R10", "blk_done at accept", blk_done, expd);
        chk(alloc_valid == 4'b0, "R3", "no early alloc", 64'(alloc_valid), 0);
        if (bad) begin
            @(negedge clk);
            chk(alloc_valid == 4'b0, "R2", "no alloc after reject", 64'(alloc_valid), 0);
            return;
        end
        mfree -= nw;
        mcnt[et] = nw;
        for (int w = 0; w < nw; w++) begin
            int c;
            int sl;
            logic [31:0] em;
            c = -1;
            for (int k = 0; k < 4; k++) begin
                int cc;
                cc = (mrr + k) % 4;
                if (c < 0) for (int i = 0; i < 16; i++) if (!mbusy[cc][i]) c = cc;
            end
            sl = -1;
            for (int i = 15; i >= 0; i--) if (!mbusy[c][i]) sl = i;
            em = ((w == nw - 1) && (T % 32 != 0)) ? ((32'd1 << (T % 32)) - 32'd1) : 32'hFFFF_FFFF;
            @(negedge clk);
            chk(alloc_valid == (4'b1 << c), "R6", "alloc_valid", 64'(alloc_valid), 64'(4'b1 << c));
            chk(alloc_slot == 4'(sl), "R7", "alloc_slot", 64'(alloc_slot), 64'(sl));
            chk(alloc_tag == 6'(et), "R9", "alloc_tag", 64'(alloc_tag), 64'(et));
            chk(alloc_warp == 5'(w), "R3", "alloc_warp", 64'(alloc_warp), 64'(w));
            chk(alloc_mask == em, "R4", "alloc_mask", 64'(alloc_mask), 64'(em));
            mbusy[c][sl] = 1;
            mtag[c][sl] = et;
            mrr = (c + 1) % 4;
        end
        @(negedge clk);
        chk(alloc_valid == 4'b0, "R3", "warp count", 64'(alloc_valid), 0);
    endtask

    task automatic retire(input int s0, input int s1, input int s2, input int s3);
        int sl[4];
        logic [63:0] expd;
        sl = '{s0, s1, s2, s3};
        expd = '0;
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            if (sl[s] >= 0) begin
                done_valid[s] = 1'b1;
                done_slot[s*4 +: 4] = 4'(sl[s]);
                retire_model(s, sl[s], expd);
            end
        end
        @(negedge clk);
        done_valid = '0;
        chk(blk_done == expd, "R8", "blk_done", blk_done, expd);
    endtask

    task automatic retire_all();
        bit any;
        any = 1;
        while (any) begin
            int p[4];
            any = 0;
            for (int s = 0; s < 4; s++) begin
                p[s] = -1;
                for (int i = 15; i >= 0; i--) if (mbusy[s][i]) p[s] = i;
                if (p[s] >= 0) any = 1;
            end
            if (any) retire(p[0], p[1], p[2], p[3]);
        end
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit acc;
        for (int t = 0; t < 64; t++) mcnt[t] = 0;
        for (int s = 0; s < 4; s++) for (int i = 0; i < 16; i++) begin
            mbusy[s][i] = 0;
            mtag[s][i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(alloc_valid == 4'b0, "R1", "alloc_valid", 64'(alloc_valid), 0);
        chk(blk_done == 64'b0, "R1", "blk_done", blk_done, 0);
        chk(req_reject == 1'b0, "R1", "reject", 64'(req_reject), 0);
        chk(req_ready == 1'b0, "R1", "ready idle", 64'(req_ready), 0);

        // R2 illegal sizes
        send_req(0, -1, 0, acc);
        chk(acc, "R2", "zero consumed", 64'(acc), 1);
        send_req(1025, -1, 0, acc);
        chk(acc, "R2", "1025 consumed", 64'(acc), 1);
        send_req(4095, -1, 0, acc);
        chk(acc, "R2", "4095 consumed", 64'(acc), 1);

        // exhaustive sweep of legal block sizes: R3, R4, R6, R7, R8, R9
        for (int T = 1; T <= 1024; T++) begin
            send_req(T, -1, 0, acc);
            chk(acc, "R5", "sweep accept", 64'(acc), 1);
            retire_all();
        end

        // R5 fill the pools, then stall
        send_req(1024, -1, 0, acc);
        send_req(1024, -1, 0, acc);
        chk(mfree == 0, "R5", "pool full", 64'(mfree), 0);
        send_req(96, -1, 0, acc);
        send_req(96, -1, 0, acc);
        retire(-1, 0, -1, -1);
        send_req(96, -1, 0, acc);
        retire(-1, 1, -1, -1);
        retire(-1, 2, -1, -1);
        // R6 only subpartition 1 has room: the others are skipped
        send_req(96, -1, 0, acc);
        chk(acc, "R6", "skip full subpartitions", 64'(acc), 1);

        // R10 admission and completion at the same edge
        retire(0, -1, -1, -1);
        send_req(32, 2, 0, acc);
        chk(acc, "R10", "accept with completion", 64'(acc), 1);
        send_req(32, -1, 0, acc);
        chk(acc, "R10", "free count after overlap", 64'(acc), 1);
        send_req(1, -1, 0, acc);
        chk(!acc, "R10", "pool exhausted", 64'(acc), 0);

        retire_all();
        send_req(1024, -1, 0, acc);
        chk(acc, "R5", "full block after drain", 64'(acc), 1);
        retire_all();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule